// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block is a bank of 8-bit configuration registers reached through a pair of I/O ports on a synchronous 8-bit bus. A write to the index port selects one of 256 register slots. A later access on the data port writes or reads the slot that the index points at. Only a small window of slots holds storage. Each slot in that window has its own write mask and its own reset value. Writes to any slot outside the window are dropped, and such slots read as zero.

Downstream decode logic sees every implemented register on a flat bus. The three registers that drive the shadow-memory decoder also have dedicated output ports. A one-cycle change strobe tells the shadow decoder to re-evaluate its map whenever one of those three registers is written.

Top module: `cfgport_regs`

## Requirements
- R1: After reset the index is 0x00 and the registers hold 0x21=0x84, 0x24=0x07, 0x25=0xF0, 0x26=0x30, 0x27=0x91, 0x28=0x80, 0x29=0x10, 0x2A=0x80 and 0x2B=0x10. Every other slot, including 0x20, 0x22 and 0x23, holds 0x00.
- R2: A write at address 0x0022 loads the index from the write data. A write at address 0x0024 stores into the slot the index selects, and the new value is visible from the next cycle on.
- R3: While the read strobe is high and the address is 0x0024, the read data shows the selected slot in that same cycle.
- R4: The read data is 0xFF whenever the read strobe is low or the address is not 0x0024. This includes a read of the index port at 0x0022.
- R5: A data write to slot 0x20 changes only bits 5:0. Bits 7:6 keep their previous value.
- R6: Data writes to slots 0x21 through 0x2B replace all 8 bits.
- R7: Data writes to any slot below 0x20 or above 0x2B have no effect, and those slots read back as 0x00.
- R8: `shadow_changed` is high for exactly the one cycle that follows a data write to slot 0x22, 0x23 or 0x26. It stays low after every other kind of access.
- R9: `shadow_ctl`, `shadow_hi_en` and `shadow_lo_ctl` always equal slots 0x22, 0x23 and 0x26.
- R10: A write at any address other than 0x0022 or 0x0024 changes neither the index nor any register.
- R11: `cfg_flat[8k+7:8k]` always equals slot 0x20+k, for k = 0 to 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | One-cycle write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid in the cycle of the read strobe |
| cfg_flat | output | 96 | Slots 0x20..0x2B, with the lowest slot in the lowest byte |
| shadow_ctl | output | 8 | Mirror of slot 0x22 |
| shadow_hi_en | output | 8 | Mirror of slot 0x23 |
| shadow_lo_ctl | output | 8 | Mirror of slot 0x26 |
| shadow_changed | output | 1 | Pulse in the cycle after a shadow-control write |

## Verification
Random accesses aim the index mostly at the window edges (0x1E to 0x2D), with a few picks from the full 8-bit range. This tells the masked slot, the fully writable slots and the dropped slots apart. Stray writes and reads at addresses near the two ports check that only the exact port addresses decode. Each data write is followed at once by a different access, so a strobe that lasts longer than one cycle, or one raised by a non-shadow slot, shows up. A directed sweep after reset reads back all 256 slots. Directed writes of 0xFF and 0x00 to slot 0x20 show that its top two bits do not move.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

  localparam int CFG_DW     = 8;
  localparam int IDX_FIRST  = 'h20;
  localparam int IDX_LAST   = 'h2B;
  localparam int NUM_IMPL   = IDX_LAST - IDX_FIRST + 1;

  typedef logic [CFG_DW-1:0] cfg_byte_t;

  // Value a slot takes under reset.
  function automatic cfg_byte_t slot_reset(input int idx);
    case (idx)
      'h21: slot_reset = 8'h84;
      'h24: slot_reset = 8'h07;
      'h25: slot_reset = 8'hF0;
      'h26: slot_reset = 8'h30;
      'h27: slot_reset = 8'h91;
      'h28: slot_reset = 8'h80;
      'h29: slot_reset = 8'h10;
      'h2A: slot_reset = 8'h80;
      'h2B: slot_reset = 8'h10;
      default: slot_reset = 8'h00;
    endcase
  endfunction

  // Bits a data write is allowed to change.
  function automatic cfg_byte_t slot_mask(input int idx);
    if (idx == 'h20)
      slot_mask = 8'h3F;
    else if (idx > 'h20 && idx <= IDX_LAST)
      slot_mask = 8'hFF;
    else
      slot_mask = 8'h00;
  endfunction

  // Slots that feed the shadow-memory decoder.
  function automatic logic slot_is_shadow(input cfg_byte_t idx);
    slot_is_shadow = (idx == 8'h22) || (idx == 8'h23) || (idx == 8'h26);
  endfunction

endpackage

// File: rtl/cfgport_decode.sv
module cfgport_decode
  import cfgport_pkg::*;
#(
  parameter int        ADDR_W    = 16,
  parameter logic [15:0] IDX_PORT  = 16'h0022,
  parameter logic [15:0] DATA_PORT = 16'h0024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  cfg_byte_t         io_wdata,
  output cfg_byte_t         index_q,
  output logic              data_wr,
  output logic              data_rd
);

  localparam logic [ADDR_W-1:0] IDX_A  = ADDR_W'(IDX_PORT);
  localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_PORT);

  logic idx_wr;

  always_comb begin
    idx_wr  = io_wr && (io_addr == IDX_A);
    data_wr = io_wr && (io_addr == DATA_A);
    data_rd = io_rd && (io_addr == DATA_A);
  end

  always_ff @(posedge clk) begin
    if (rst)
      index_q <= '0;
    else if (idx_wr)
      index_q <= io_wdata;
  end

  AST_IDX_LOAD: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_addr == IDX_A) |=> (index_q == $past(io_wdata))); // R2

  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(io_wr && io_addr == IDX_A) |=> $stable(index_q)); // R10

endmodule

// File: rtl/cfgport_bank.sv
module cfgport_bank
  import cfgport_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  cfg_byte_t                index_q,
  input  logic                     data_wr,
  input  cfg_byte_t                io_wdata,
  output logic [NUM_IMPL*CFG_DW-1:0] slots_flat,
  output cfg_byte_t                sel_value
);

  cfg_byte_t slot_q [NUM_IMPL];

  for (genvar k = 0; k < NUM_IMPL; k++) begin : g_slot
    localparam int        IDX  = IDX_FIRST + k;
    localparam cfg_byte_t RVAL = slot_reset(IDX);
    localparam cfg_byte_t MASK = slot_mask(IDX);

    logic hit;
    assign hit = data_wr && (index_q == CFG_DW'(IDX));

    always_ff @(posedge clk) begin
      if (rst)
        slot_q[k] <= RVAL;
      else if (hit)
        slot_q[k] <= (slot_q[k] & ~MASK) | (io_wdata & MASK);
    end

    assign slots_flat[k*CFG_DW +: CFG_DW] = slot_q[k];

    AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (rst)
      !(data_wr && index_q == CFG_DW'(IDX)) |=> $stable(slot_q[k])); // R10

    if (MASK != 8'hFF) begin : g_keep
      AST_TOP_KEEP: assert property (@(posedge clk) disable iff (rst)
        data_wr |=> ((slot_q[k] & ~MASK) == ($past(slot_q[k]) & ~MASK))); // R5
    end
  end

  // Read path: slots outside the window read as zero.
  always_comb begin
    sel_value = '0;
    for (int k = 0; k < NUM_IMPL; k++) begin
      if (index_q == CFG_DW'(IDX_FIRST + k))
        sel_value = slot_q[k];
    end
  end

endmodule

// File: rtl/cfgport_strobe.sv
module cfgport_strobe
  import cfgport_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      data_wr,
  input  cfg_byte_t index_q,
  output logic      shadow_changed
);

  always_ff @(posedge clk) begin
    if (rst)
      shadow_changed <= 1'b0;
    else
      shadow_changed <= data_wr && slot_is_shadow(index_q);
  end

  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (data_wr && (index_q == 8'h22 || index_q == 8'h23 || index_q == 8'h26))
      |=> shadow_changed); // R8

  AST_PULSE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !data_wr |=> !shadow_changed); // R8

endmodule

// File: rtl/cfgport_regs.sv
module cfgport_regs
  import cfgport_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] IDX_PORT  = 16'h0022,
  parameter logic [15:0] DATA_PORT = 16'h0024,
  parameter logic [7:0]  IDLE_READ = 8'hFF
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ADDR_W-1:0]          io_addr,
  input  logic                       io_wr,
  input  logic                       io_rd,
  input  logic [7:0]                 io_wdata,
  output logic [7:0]                 io_rdata,
  output logic [NUM_IMPL*CFG_DW-1:0] cfg_flat,
  output logic [7:0]                 shadow_ctl,
  output logic [7:0]                 shadow_hi_en,
  output logic [7:0]                 shadow_lo_ctl,
  output logic                       shadow_changed
);

  localparam int OFS_CTL = 'h22 - IDX_FIRST;
  localparam int OFS_HI  = 'h23 - IDX_FIRST;
  localparam int OFS_LO  = 'h26 - IDX_FIRST;

  cfg_byte_t index_q;
  cfg_byte_t sel_value;
  logic      data_wr;
  logic      data_rd;

  cfgport_decode #(
    .ADDR_W   (ADDR_W),
    .IDX_PORT (IDX_PORT),
    .DATA_PORT(DATA_PORT)
  ) u_decode (
    .clk     (clk),
    .rst     (rst),
    .io_addr (io_addr),
    .io_wr   (io_wr),
    .io_rd   (io_rd),
    .io_wdata(io_wdata),
    .index_q (index_q),
    .data_wr (data_wr),
    .data_rd (data_rd)
  );

  cfgport_bank u_bank (
    .clk       (clk),
    .rst       (rst),
    .index_q   (index_q),
    .data_wr   (data_wr),
    .io_wdata  (io_wdata),
    .slots_flat(cfg_flat),
    .sel_value (sel_value)
  );

  cfgport_strobe u_strobe (
    .clk           (clk),
    .rst           (rst),
    .data_wr       (data_wr),
    .index_q       (index_q),
    .shadow_changed(shadow_changed)
  );

  assign io_rdata      = data_rd ? sel_value : IDLE_READ;
  assign shadow_ctl    = cfg_flat[OFS_CTL*CFG_DW +: CFG_DW];
  assign shadow_hi_en  = cfg_flat[OFS_HI*CFG_DW +: CFG_DW];
  assign shadow_lo_ctl = cfg_flat[OFS_LO*CFG_DW +: CFG_DW];

  AST_IDLE_READ: assert property (@(posedge clk) disable iff (rst)
    !(io_rd && io_addr == ADDR_W'(DATA_PORT)) |-> (io_rdata == IDLE_READ)); // R4

  AST_SHADOW_WRITE: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_addr == ADDR_W'(DATA_PORT) && index_q == 8'h23)
      |=> (shadow_hi_en == $past(io_wdata))); // R6

endmodule

// File: tb/cfgport_regs_tb.sv
module cfgport_regs_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] io_addr;
  logic        io_wr;
  logic        io_rd;
  logic [7:0]  io_wdata;
  logic [7:0]  io_rdata;
  logic [95:0] cfg_flat;
  logic [7:0]  shadow_ctl, shadow_hi_en, shadow_lo_ctl;
  logic        shadow_changed;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [7:0] model [256];
  logic [7:0] m_index;
  logic       exp_pulse;

  always #4 clk = ~clk;

  cfgport_regs u_dut (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .cfg_flat(cfg_flat),
    .shadow_ctl(shadow_ctl), .shadow_hi_en(shadow_hi_en),
    .shadow_lo_ctl(shadow_lo_ctl), .shadow_changed(shadow_changed)
  );

  function automatic logic [7:0] rst_val(input int i);
    case (i)
      'h21: return 8'h84; 'h24: return 8'h07; 'h25: return 8'hF0;
      'h26: return 8'h30; 'h27: return 8'h91; 'h28: return 8'h80;
      'h29: return 8'h10; 'h2A: return 8'h80; 'h2B: return 8'h10;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] apply_write(input int i, input logic [7:0] old_v,
                                             input logic [7:0] v);
    if (i == 'h20) return {old_v[7:6], v[5:0]};
    if (i >= 'h21 && i <= 'h2B) return v;
    return old_v;
  endfunction

  task automatic check(input string tag, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_mirrors();
    logic [95:0] ef;
    for (int k = 0; k < 12; k++) ef[k*8 +: 8] = model['h20 + k];
    check("R11 cfg_flat", cfg_flat, ef);
    check("R9 shadow_ctl", {88'h0, shadow_ctl}, {88'h0, model['h22]});
    check("R9 shadow_hi_en", {88'h0, shadow_hi_en}, {88'h0, model['h23]});
    check("R9 shadow_lo_ctl", {88'h0, shadow_lo_ctl}, {88'h0, model['h26]});
    check("R8 shadow_changed", {95'h0, shadow_changed}, {95'h0, exp_pulse});
  endtask

  // Drive at negedge, finish at the next negedge and check.
  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    io_wr = 1'b0;
    exp_pulse = 1'b0;
    if (a == 16'h0022) m_index = d;
    else if (a == 16'h0024) begin
      exp_pulse = (m_index == 8'h22) || (m_index == 8'h23) || (m_index == 8'h26);
      model[m_index] = apply_write(int'(m_index), model[m_index], d);
    end
    check_mirrors();
  endtask

  task automatic io_read(input logic [15:0] a, input string tag);
    logic [7:0] e;
    io_addr = a; io_rd = 1'b1;
    #2;
    e = (a == 16'h0024) ? model[m_index] : 8'hFF;
    check(tag, {88'h0, io_rdata}, {88'h0, e});
    @(posedge clk);
    @(negedge clk);
    io_rd = 1'b0;
    exp_pulse = 1'b0;
    #1;
    check("R4 idle rdata", {88'h0, io_rdata}, 96'hFF);
    check_mirrors();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] a;
    logic [7:0]  d;
    int          sel;
    void'($urandom(32'd1234));
    rst = 1'b1; io_wr = 1'b0; io_rd = 1'b0; io_addr = '0; io_wdata = '0;
    for (int i = 0; i < 256; i++) model[i] = rst_val(i);
    m_index = 8'h00;
    exp_pulse = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check_mirrors();

    // R1: index starts at 0x00 and every slot holds its reset value
    io_read(16'h0024, "R1 reset index 0");
    for (int i = 0; i < 256; i++) begin
      io_write(16'h0022, 8'(i));
      io_read(16'h0024, "R1 reset value");
    end
    io_read(16'h0022, "R4 index port read");

    // R5: top bits of slot 0x20 never move
    io_write(16'h0022, 8'h20);
    io_write(16'h0024, 8'hFF);
    io_read(16'h0024, "R5 masked 0xFF");
    io_write(16'h0024, 8'h00);
    io_read(16'h0024, "R5 masked 0x00");
    // R8: back-to-back shadow writes keep the strobe high
    io_write(16'h0022, 8'h26);
    io_write(16'h0024, 8'hA5);
    io_write(16'h0024, 8'h5A);
    io_write(16'h0022, 8'h27);
    io_write(16'h0024, 8'h3C);
    // R7: slot outside the window
    io_write(16'h0022, 8'h2C);
    io_write(16'h0024, 8'h77);
    io_read(16'h0024, "R7 out of window");
    // R10: stray addresses
    io_write(16'h0023, 8'h22);
    io_write(16'h0124, 8'h99);
    io_read(16'h0024, "R10 stray write");

    for (int n = 0; n < 3000; n++) begin
      sel = $urandom_range(0, 9);
      d = 8'($urandom);
      if (sel < 3) begin
        if ($urandom_range(0, 7) == 0) io_write(16'h0022, d);
        else io_write(16'h0022, 8'($urandom_range('h1E, 'h2D)));
      end else if (sel < 6) begin
        io_write(16'h0024, d);
      end else if (sel < 8) begin
        io_read(16'h0024, "R3 random read");
      end else begin
        a = 16'h0020 + 16'($urandom_range(0, 7));
        if ($urandom_range(0, 1) == 0) io_read(a, "R4 random addr read");
        else io_write(a, d);
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule